// File: doc/BRIEF.md
# Shift-Add Output Post-processor for a Sine-Transform Systolic Array

This stage sits behind a six-cell linear array that computes two half-transforms in turn, first an "a" pass and then a "b" pass. It receives each array result as a signed fixed-point word. Each result is scaled by a fixed sine coefficient. That coefficient is built only from shifted copies of the input and adders or subtractors, with no general multiplier. The stage then subtracts the stored final recurrence value for the current pass. It doubles the difference, applies a sign, saturates the result and tags it with the transform index where the host must place it.

Results arrive in a fixed slot order. That order fixes the coefficient, the intermediate index k and the sign used for each result. The host keeps both stored recurrence values on the `xmA`/`xmB` inputs and gathers the indexed stream. The final output recursion runs on the host.

Top module: `sapp_top`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `outVld` is 0.
- R2: Each accepted input (`inVld` high at a rising edge) produces exactly one output, with `outVld` high two rising edges later. In-order delivery is kept.
- R3: Accepted inputs are numbered in slots 0..5 within a pass. The first six after reset belong to pass a (`outPassB`=0), the next six to pass b (`outPassB`=1), and the passes alternate from then on.
- R4: The slots map to the intermediate index k as 4,5,3,6,1,2. In pass a, `outIdx` = 2k, so slots 0..5 give 8,10,6,12,2,4.
- R5: In pass b, `outIdx` = MIDX−2k. With the default MIDX=13, slots 0..5 give 5,3,7,1,11,9.
- R6: The coefficients, in units of 2^-9, are as follows for slots 0..5: 421, 479, 340, 508, 123, 238. Each coefficient is formed from at most five signed power-of-two terms.
- R7: The intermediate value is y = floor(r·C/512) − xm. Here r is `inData`, C is the slot coefficient, and xm is `xmA` in pass a or `xmB` in pass b, sampled with `inData`.
- R8: The output value is 2y, negated when k is odd in pass a or when k is even in pass b.
- R9: Values outside the signed DW-bit range are clamped to the largest or smallest representable value.
- R10: Cycles with `inVld` low advance neither slot nor pass and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inVld | input | 1 | Array result valid |
| inData | input | DW | Signed array result |
| xmA | input | DW | Stored final recurrence value, pass a |
| xmB | input | DW | Stored final recurrence value, pass b |
| outVld | output | 1 | Output valid |
| outIdx | output | 4 | Transform index of this output |
| outPassB | output | 1 | Output belongs to pass b |
| outData | output | DW | Signed, doubled, saturated result |

## Verification
The assertions check several things on every cycle:
- the two-cycle valid pipeline and its silence during reset;
- the slot counter's range and its hold on idle cycles;
- the pass toggling at the end of a slot sequence;
- the parity and range of the emitted index.

Only the bench scenarios can show the arithmetic. These are the exact coefficient values, the floor-rounded subtraction of the correct pass's stored value, the sign rule per slot and pass, and clamping at both rails. They are checked against a model built from the coefficients in integer form, under directed unit inputs, extreme inputs and random inputs with random idle gaps.

// File: rtl/sapp_pkg.sv
package sapp_pkg;
  localparam int NSLOT = 6;
  localparam int SLOTW = 3;
  localparam int FRAC  = 9;
  localparam int IDXW  = 4;

  typedef struct packed {
    logic             vld;
    logic [SLOTW-1:0] slot;
    logic             passB;
  } strobe_t;

  // Intermediate index k for each arrival slot.
  function automatic logic [2:0] kOfSlot(logic [SLOTW-1:0] s);
    case (s)
      3'd0:    kOfSlot = 3'd4;
      3'd1:    kOfSlot = 3'd5;
      3'd2:    kOfSlot = 3'd3;
      3'd3:    kOfSlot = 3'd6;
      3'd4:    kOfSlot = 3'd1;
      3'd5:    kOfSlot = 3'd2;
      default: kOfSlot = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/sapp_ctrl.sv
module sapp_ctrl
  import sapp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inVld,
  output strobe_t strb
);
  localparam logic [SLOTW-1:0] LAST = SLOTW'(NSLOT - 1);

  logic [SLOTW-1:0] slotCnt;
  logic             passB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
      passB   <= 1'b0;
    end else if (inVld) begin
      if (slotCnt == LAST) begin
        slotCnt <= '0;
        passB   <= ~passB;
      end else begin
        slotCnt <= slotCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.vld   = inVld;
    strb.slot  = slotCnt;
    strb.passB = passB;
  end

  // R3: slot stays inside the six-entry sequence
  a_r3_slot_range: assert property (@(posedge clk) disable iff (!rstN)
    slotCnt <= LAST);

  // R3: pass flips after the last slot is accepted
  a_r3_pass_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (inVld && slotCnt == LAST) |=> (passB != $past(passB)) && (slotCnt == '0));

  // R10: idle cycles leave the sequence where it was
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |=> $stable(slotCnt) && $stable(passB));
endmodule

// File: rtl/sapp_dp.sv
module sapp_dp
  import sapp_pkg::*;
#(
  parameter int DW   = 16,
  parameter int MIDX = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic signed [DW-1:0] inData,
  input  logic signed [DW-1:0] xmA,
  input  logic signed [DW-1:0] xmB,
  output logic                 outVld,
  output logic [IDXW-1:0]      outIdx,
  output logic                 outPassB,
  output logic signed [DW-1:0] outData
);
  localparam int PW = DW + FRAC + 2;
  localparam int YW = DW + 3;
  localparam int VW = YW + 2;
  localparam logic signed [VW-1:0] VMAX = VW'((longint'(1) <<< (DW - 1)) - 1);
  localparam logic signed [VW-1:0] VMIN = -VW'(longint'(1) <<< (DW - 1));

  logic signed [PW-1:0] rx;
  logic signed [PW-1:0] prods [NSLOT];
  logic signed [PW-1:0] prodSel;
  logic signed [PW-1:0] scaled;
  logic signed [DW-1:0] xmSel;
  logic signed [YW-1:0] yNext;

  assign rx = {{(PW-DW){inData[DW-1]}}, inData};

  // Fixed shift-add coefficient multipliers, one per slot.
  for (genvar g = 0; g < NSLOT; g++) begin : gMul
    if (g == 0) begin : gC421
      assign prods[g] = (rx <<< 9) - (rx <<< 7) + (rx <<< 5) + (rx <<< 2) + rx;
    end else if (g == 1) begin : gC479
      assign prods[g] = (rx <<< 9) - (rx <<< 5) - rx;
    end else if (g == 2) begin : gC340
      assign prods[g] = (rx <<< 8) + (rx <<< 6) + (rx <<< 4) + (rx <<< 2);
    end else if (g == 3) begin : gC508
      assign prods[g] = (rx <<< 9) - (rx <<< 2);
    end else if (g == 4) begin : gC123
      assign prods[g] = (rx <<< 7) - (rx <<< 2) - rx;
    end else begin : gC238
      assign prods[g] = (rx <<< 8) - (rx <<< 4) - (rx <<< 1);
    end
  end

  always_comb begin
    prodSel = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (strb.slot == SLOTW'(i)) prodSel = prods[i];
    end
    scaled = prodSel >>> FRAC;
    xmSel  = strb.passB ? xmB : xmA;
    yNext  = YW'(scaled) - YW'(xmSel);
  end

  // Stage 1: scaled and offset value.
  logic                 s1Vld;
  logic [SLOTW-1:0]     s1Slot;
  logic                 s1PassB;
  logic signed [YW-1:0] s1Y;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Vld   <= 1'b0;
      s1Slot  <= '0;
      s1PassB <= 1'b0;
      s1Y     <= '0;
    end else begin
      s1Vld <= strb.vld;
      if (strb.vld) begin
        s1Slot  <= strb.slot;
        s1PassB <= strb.passB;
        s1Y     <= yNext;
      end
    end
  end

  // Stage 2: index, sign, doubling, clamp.
  logic [2:0]           kVal;
  logic                 negate;
  logic [IDXW-1:0]      idxNext;
  logic signed [VW-1:0] dbl;
  logic signed [VW-1:0] signedVal;
  logic signed [DW-1:0] satVal;

  always_comb begin
    kVal      = kOfSlot(s1Slot);
    negate    = s1PassB ? ~kVal[0] : kVal[0];
    idxNext   = s1PassB ? (IDXW'(MIDX) - IDXW'({kVal, 1'b0})) : IDXW'({kVal, 1'b0});
    dbl       = VW'(s1Y) <<< 1;
    signedVal = negate ? -dbl : dbl;
    if (signedVal > VMAX)      satVal = DW'(VMAX);
    else if (signedVal < VMIN) satVal = DW'(VMIN);
    else                       satVal = DW'(signedVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outVld   <= 1'b0;
      outIdx   <= '0;
      outPassB <= 1'b0;
      outData  <= '0;
    end else begin
      outVld <= s1Vld;
      if (s1Vld) begin
        outIdx   <= idxNext;
        outPassB <= s1PassB;
        outData  <= satVal;
      end
    end
  end

  // R1: nothing leaves the block while held in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !outVld);

  // R2: every accepted input emerges two edges later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    strb.vld |=> ##1 outVld);

  // R10: no output without an input two edges earlier
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !strb.vld |=> ##1 !outVld);

  // R4: pass a indices are even
  a_r4_even_idx: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && !outPassB) |-> (outIdx[0] == 1'b0) && (outIdx != '0));

  // R5: pass b indices stay inside the transform length
  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && outPassB) |-> (outIdx <= IDXW'(MIDX)));
endmodule

// File: rtl/sapp_top.sv
module sapp_top
  import sapp_pkg::*;
#(
  parameter int DW   = 16,
  parameter int MIDX = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inVld,
  input  logic signed [DW-1:0] inData,
  input  logic signed [DW-1:0] xmA,
  input  logic signed [DW-1:0] xmB,
  output logic                 outVld,
  output logic [IDXW-1:0]      outIdx,
  output logic                 outPassB,
  output logic signed [DW-1:0] outData
);
  strobe_t strb;

  sapp_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .inVld (inVld),
    .strb  (strb)
  );

  sapp_dp #(.DW(DW), .MIDX(MIDX)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inData   (inData),
    .xmA      (xmA),
    .xmB      (xmB),
    .outVld   (outVld),
    .outIdx   (outIdx),
    .outPassB (outPassB),
    .outData  (outData)
  );
endmodule

// File: tb/sapp_top_bench.sv
module sapp_top_bench;
  localparam int DW   = 16;
  localparam int MIDX = 13;
  localparam int QD   = 1024;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inVld = 1'b0;
  logic signed [DW-1:0] inData = '0;
  logic signed [DW-1:0] xmA = '0;
  logic signed [DW-1:0] xmB = '0;
  logic                 outVld;
  logic [3:0]           outIdx;
  logic                 outPassB;
  logic signed [DW-1:0] outData;

  always #2.5 clk = ~clk;

  sapp_top #(.DW(DW), .MIDX(MIDX)) u_sapp_top (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inData(inData),
    .xmA(xmA), .xmB(xmB), .outVld(outVld), .outIdx(outIdx),
    .outPassB(outPassB), .outData(outData)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  longint qVal [QD];
  int     qIdx [QD];
  bit     qPb  [QD];
  int     qCyc [QD];
  string  qReq [QD];
  int head = 0;
  int tail = 0;
  int bSlot = 0;
  bit bPass = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int kOf(int s);
    case (s)
      0: return 4; 1: return 5; 2: return 3;
      3: return 6; 4: return 1; default: return 2;
    endcase
  endfunction

  function automatic longint coefOf(int s);
    case (s)
      0: return 421; 1: return 479; 2: return 340;
      3: return 508; 4: return 123; default: return 238;
    endcase
  endfunction

  function automatic longint model(int s, bit pb, longint r, longint xm);
    longint y, v;
    int k;
    k = kOf(s);
    y = ((r * coefOf(s)) >>> 9) - xm;
    v = 2 * y;
    if (pb ? (k % 2 == 0) : (k % 2 == 1)) v = -v;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  function automatic bit saturates(int s, bit pb, longint r, longint xm);
    longint y;
    y = ((r * coefOf(s)) >>> 9) - xm;
    return (2 * y > 32767) || (2 * y < -32767);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendOne(longint r, longint xa, longint xb, string req);
    longint xm;
    @(posedge clk); #1;
    inVld  = 1'b1;
    inData = DW'(r);
    xmA    = DW'(xa);
    xmB    = DW'(xb);
    xm = bPass ? xb : xa;
    qVal[tail % QD] = model(bSlot, bPass, r, xm);
    qIdx[tail % QD] = bPass ? (MIDX - 2 * kOf(bSlot)) : 2 * kOf(bSlot);
    qPb[tail % QD]  = bPass;
    qCyc[tail % QD] = cyc + 2;
    qReq[tail % QD] = (req == "R7" && saturates(bSlot, bPass, r, xm)) ? "R9" : req;
    tail++;
    if (bSlot == 5) begin bSlot = 0; bPass = ~bPass; end
    else bSlot++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      inVld  = 1'b0;
      inData = DW'($urandom);
    end
  endtask

  // Output monitor, sampled at the falling edge.
  always @(negedge clk) begin
    if (rstN && outVld && !done) begin
      if (head == tail) begin
        check(0, "R10 unexpected output", 1, 0);
      end else begin
        check(cyc == qCyc[head % QD], "R2 latency", cyc, qCyc[head % QD]);
        check(outPassB == qPb[head % QD], "R3 pass", outPassB, qPb[head % QD]);
        check(int'(outIdx) == qIdx[head % QD],
              qPb[head % QD] ? "R5 index" : "R4 index", outIdx, qIdx[head % QD]);
        check(longint'(outData) == qVal[head % QD],
              {qReq[head % QD], " R8 value"}, outData, qVal[head % QD]);
        head++;
      end
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    // R1: quiet during and just after reset
    repeat (3) @(posedge clk);
    #1 check(outVld == 1'b0, "R1 during reset", outVld, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(outVld == 1'b0, "R1 after reset", outVld, 0);

    // R6: unit input exposes each coefficient, both passes
    for (int i = 0; i < 12; i++) sendOne(512, 0, 0, "R6");
    idle(4);
    // R9: drive both rails
    for (int i = 0; i < 12; i++) sendOne(32767, -32768, 32767, "R9");
    for (int i = 0; i < 12; i++) sendOne(-32768, 32767, -32768, "R9");
    idle(4);
    // R7: zero data leaves only the stored value
    for (int i = 0; i < 12; i++) sendOne(0, 100 + i, -7 - i, "R7");
    // R7 R10: random values with random idle gaps
    for (int i = 0; i < 600; i++) begin
      longint r, xa, xb;
      if ($urandom_range(0, 9) == 0) r = longint'($urandom_range(0, 65535)) - 32768;
      else r = longint'($urandom_range(0, 8191)) - 4096;
      xa = longint'($urandom_range(0, 8191)) - 4096;
      xb = longint'($urandom_range(0, 8191)) - 4096;
      sendOne(r, xa, xb, "R7");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(6);
    // R10: every queued output delivered, nothing extra
    check(head == tail, "R10 output count", head, tail);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule